// File: doc/BRIEF.md
# Page-Gathering Write Sequencer

This block is the write-side control of a synchronous model of a byte-wide nonvolatile memory. The host issues byte writes with active-low chip-enable, write-enable and output-enable strobes, which the block samples on the clock. Each accepted byte goes into a page buffer. All bytes of one load share a page number taken from the upper address bits. Each new byte reopens a timing window. When the window closes with no new byte, a self-timed programming phase starts. At the end of that phase the buffered bytes are copied into a behavioural array.

During programming the block answers every read with a status byte instead of array data. The top bit is the complement of bit 7 of the last accepted byte. The next bit flips on each new read. Software polls either bit to learn when programming has finished. Outside programming, reads return array contents one clock later. The output is marked undriven whenever the chip or its output is not enabled.

Top module: `page_write_seq`

## Requirements
- R1: A write cycle is recognised only while ce_n=0, we_n=0 and oe_n=1 are sampled together. A strobe pattern with oe_n=0 starts no load and changes no array byte.
- R2: The byte address is taken in the first clock of a write cycle. The data is the din value sampled in the last clock in which the write condition still held. Address changes after the first clock have no effect.
- R3: addr[16:8] is the page number and addr[7:0] the byte offset. The buffer holds up to 256 bytes, and a second write to the same offset replaces the first. Programming stores only the bytes loaded. The array keeps ARRAY_PAGES pages and uses the page number modulo ARRAY_PAGES.
- R4: While each new write starts within LOAD_WIN clocks of the previous accepted write start, busy stays 0. A read with we_n=1 between writes does not end the load. That read returns the array contents from before the load.
- R5: With the strobes idle, busy rises exactly LOAD_WIN clocks after the first clock of the last accepted write.
- R6: busy stays 1 for exactly PROG_CYC clocks and then the array holds the new bytes. Writes issued while busy=1 are ignored and start no new load.
- R7: During programming every read returns a status byte. Bit 7 is the complement of bit 7 of the last accepted data, and bits 5:0 are 0.
- R8: Bit 6 of the status byte is a toggle register that resets to 0. It inverts at the first clock of each read during programming and is shown after inverting. It holds its value outside programming.
- R9: A write during a load whose page number differs from the load's page is discarded. It does not reopen the window, and it sets page_err, which stays 1 until reset.
- R10: Outside programming, a read returns the array byte on dout with dout_en=1 at the clock after its first sampled clock. dout_en is 0 in the clock after any cycle with ce_n=1 or oe_n=1, and dout is 0 whenever dout_en is 0.
- R11: After reset, dout_en=0, dout=0, busy=0 and page_err=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low, already synchronous to clk |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address; upper 9 bits page number, lower 8 bits offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or programming status |
| dout_en | output | 1 | 1 when dout is driven; 0 means high impedance |
| busy | output | 1 | 1 during the programming phase |
| page_err | output | 1 | Sticky flag for a discarded write to a foreign page |

## Verification
Suppose the window counter were restarted by a discarded write, or never restarted. The rising edge of busy would then fall a few clocks off the exact cycle the bench predicts, and that shows at once. A byte-buffer fault, such as a lost valid bit, a wrong offset or a wrong capture cycle for the data, stays hidden until the phase ends. It shows on the first readback after busy falls. A toggle register that moves outside programming, or a wrong last-data bit, corrupts the next status read. Status reads are made in two pages whose last bytes have opposite bit 7, so a stuck polarity cannot pass.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pws_strobe.sv
// Turns sampled strobes into write start/end and read start pulses,
// and latches the byte offset and the data of a write cycle.
module pws_strobe #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [DATA_W-1:0] din,
  output logic              wr_act,
  output logic              wr_start,
  output logic              wr_end,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_act,
  output logic              rd_start
);
  logic              wr_q, rd_q;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  always_comb begin
    wr_act   = !ce_n && !we_n && oe_n;
    rd_act   = !ce_n && !oe_n && we_n;
    wr_start = wr_act && !wr_q;
    wr_end   = !wr_act && wr_q;
    rd_start = rd_act && !rd_q;
    off_d    = wr_start ? off_in : off_q;
    dat_d    = wr_act ? din : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      off_q <= '0;
      dat_q <= '0;
    end else begin
      wr_q  <= wr_act;
      rd_q  <= rd_act;
      off_q <= off_d;
      dat_q <= dat_d;
    end
  end

  assign wr_off  = off_q;
  assign wr_data = dat_q;

  // R2: the offset cannot move while a write cycle is still running
  a_r2_off_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_q) |=> $stable(off_q));
endmodule

// File: rtl/pws_ctrl.sv
// Sequencer: load window timer, programming timer, page tracking and status bits.
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int PAGE_W   = 9,
  parameter int LOAD_WIN = 5000,
  parameter int PROG_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic [PAGE_W-1:0] start_page,
  input  logic              wr_msb,
  input  logic              rd_start,
  output seq_state_t        st,
  output logic [PAGE_W-1:0] page,
  output logic              buf_we,
  output logic              commit,
  output logic              page_err,
  output logic              last_msb,
  output logic              tog_nx
);
  localparam int WIN_W = (LOAD_WIN > 2) ? $clog2(LOAD_WIN) : 1;
  localparam int PC_W  = (PROG_CYC > 2) ? $clog2(PROG_CYC) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOAD_WIN - 1);
  localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PROG_CYC - 1);

  seq_state_t        st_q, st_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              acc_q, acc_d;
  logic              err_q, err_d;
  logic              msb_q, msb_d;
  logic              tog_q, tog_d;

  always_comb begin
    st_d   = st_q;
    win_d  = win_q;
    pc_d   = pc_q;
    page_d = page_q;
    acc_d  = acc_q;
    err_d  = err_q;
    msb_d  = msb_q;
    tog_d  = tog_q;
    buf_we = 1'b0;
    commit = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_start) begin
          st_d   = ST_LOAD;
          page_d = start_page;
          acc_d  = 1'b1;
          win_d  = '0;
        end
      end
      ST_LOAD: begin
        if (wr_start) begin
          if (start_page == page_q) begin
            acc_d = 1'b1;
            win_d = '0;
          end else begin
            acc_d = 1'b0;
            err_d = 1'b1;
            if (win_q != WIN_LAST) win_d = win_q + 1'b1;
          end
        end else if (win_q != WIN_LAST) begin
          win_d = win_q + 1'b1;
        end
        if (wr_end && acc_q) begin
          buf_we = 1'b1;
          msb_d  = wr_msb;
          acc_d  = 1'b0;
        end
        if (!wr_act && win_q == WIN_LAST) begin
          st_d = ST_PROG;
          pc_d = '0;
        end
      end
      ST_PROG: begin
        if (rd_start) tog_d = ~tog_q;
        if (pc_q == PC_LAST) begin
          commit = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      pc_q   <= '0;
      page_q <= '0;
      acc_q  <= 1'b0;
      err_q  <= 1'b0;
      msb_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      win_q  <= win_d;
      pc_q   <= pc_d;
      page_q <= page_d;
      acc_q  <= acc_d;
      err_q  <= err_d;
      msb_q  <= msb_d;
      tog_q  <= tog_d;
    end
  end

  assign st       = st_q;
  assign page     = page_q;
  assign page_err = err_q;
  assign last_msb = msb_q;
  assign tog_nx   = tog_d;

  // R9: the foreign-page flag never clears without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R5: a running write cycle keeps the load open
  a_r5_no_close_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && wr_act) |=> st_q == ST_LOAD);
  // R6: programming runs until its counter reaches the end
  a_r6_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROG && pc_q != PC_LAST) |=> st_q == ST_PROG);
  // R6: no load can begin straight out of programming
  a_r6_no_load_from_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROG) |=> st_q != ST_LOAD);
  // R8: the toggle register is frozen outside programming
  a_r8_tog_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_PROG) |=> $stable(tog_q));
endmodule

// File: rtl/pws_page_buf.sv
// Page buffer: one data register and one valid flag per byte offset.
module pws_page_buf #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [OFF_W-1:0]              waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          clr,
  output logic [(1<<OFF_W)-1:0]             vld,
  output logic [(1<<OFF_W)-1:0][DATA_W-1:0] dat
);
  localparam int DEPTH = 1 << OFF_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit;
    logic vld_d;
    assign hit   = we && (waddr == OFF_W'(g));
    assign vld_d = clr ? 1'b0 : (hit ? 1'b1 : vld[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld[g] <= 1'b0;
      else        vld[g] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit) dat[g] <= wdata;
    end
  end

  // R3: after programming copies the page, no stale byte stays marked
  a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !we) |=> $countones(vld) == 0);
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 8,
  parameter int ARRAY_PAGES = 8,
  parameter int LOAD_WIN    = 5000,
  parameter int PROG_CYC    = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_W    = ADDR_W - OFF_W;
  localparam int DEPTH     = 1 << OFF_W;
  localparam int IDX_W     = $clog2(ARRAY_PAGES);
  localparam int ARR_DEPTH = ARRAY_PAGES * DEPTH;

  // reset: asserted at once, removed on a clock edge
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic              wr_act, wr_start, wr_end, rd_act, rd_start;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_data;

  pws_strobe #(.OFF_W(OFF_W), .DATA_W(DATA_W)) i_strobe (
    .clk(clk), .rst_n(rst_s), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .off_in(addr[OFF_W-1:0]), .din(din),
    .wr_act(wr_act), .wr_start(wr_start), .wr_end(wr_end),
    .wr_off(wr_off), .wr_data(wr_data), .rd_act(rd_act), .rd_start(rd_start)
  );

  seq_state_t        st;
  logic [PAGE_W-1:0] page;
  logic              buf_we, commit, last_msb, tog_nx;

  pws_ctrl #(.PAGE_W(PAGE_W), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_s), .wr_act(wr_act), .wr_start(wr_start),
    .wr_end(wr_end), .start_page(addr[ADDR_W-1:OFF_W]),
    .wr_msb(wr_data[DATA_W-1]), .rd_start(rd_start),
    .st(st), .page(page), .buf_we(buf_we), .commit(commit),
    .page_err(page_err), .last_msb(last_msb), .tog_nx(tog_nx)
  );

  logic [DEPTH-1:0]             buf_vld;
  logic [DEPTH-1:0][DATA_W-1:0] buf_dat;

  pws_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) i_buf (
    .clk(clk), .rst_n(rst_s), .we(buf_we), .waddr(wr_off), .wdata(wr_data),
    .clr(commit), .vld(buf_vld), .dat(buf_dat)
  );

  // behavioural array
  logic [DATA_W-1:0] arr [ARR_DEPTH];
  logic [IDX_W-1:0]  cpage;
  assign cpage = page[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (buf_vld[i]) arr[{cpage, OFF_W'(i)}] <= buf_dat[i];
      end
    end
  end

  // read path, one registered stage
  logic [DATA_W-1:0] status, dout_d, dout_q;
  logic              en_q;
  logic [IDX_W+OFF_W-1:0] rd_idx;

  always_comb begin
    rd_idx           = {addr[OFF_W+IDX_W-1:OFF_W], addr[OFF_W-1:0]};
    status           = '0;
    status[DATA_W-1] = ~last_msb;
    status[DATA_W-2] = tog_nx;
    dout_d           = '0;
    if (rd_act) dout_d = (st == ST_PROG) ? status : arr[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dout_q <= '0;
      en_q   <= 1'b0;
    end else begin
      dout_q <= dout_d;
      en_q   <= rd_act;
    end
  end

  assign dout    = dout_q;
  assign dout_en = en_q;
  assign busy    = (st == ST_PROG);

  // R10: no drive one clock after chip or output disable
  a_r10_hiz: assert property (@(posedge clk) disable iff (!rst_s)
    (ce_n || oe_n) |=> !dout_en);
  // R3: buffer only written while a load is open
  a_r3_buf_in_load: assert property (@(posedge clk) disable iff (!rst_s)
    buf_we |-> !busy);
endmodule

// File: tb/test_page_write_seq.sv
module test_page_write_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 20;
  localparam int PC = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n;
  logic [16:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en, busy, page_err;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_seq #(.LOAD_WIN(LW), .PROG_CYC(PC)) i_page_write_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .page_err(page_err)
  );

  // {address, write data, expected readback}; all in page 5
  localparam int NV = 7;
  localparam logic [32:0] VEC [NV] = '{
    {17'h00500, 8'hA5, 8'hA5},
    {17'h00512, 8'h11, 8'h99},
    {17'h005FF, 8'h80, 8'h80},
    {17'h00512, 8'h99, 8'h99},
    {17'h00501, 8'h7E, 8'h7E},
    {17'h00540, 8'h00, 8'h00},
    {17'h0057F, 8'hC3, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic oe);
    ce_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = a; din = d;
    step(2);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(1);
  endtask

  task automatic rd(input string req, input logic [16:0] a, input logic [7:0] exp);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    step(1);
    chk(req, {31'd0, dout_en}, 32'd1);
    chk(req, {24'd0, dout}, {24'd0, exp});
    ce_n = 1'b1; oe_n = 1'b1;
    step(1);
  endtask

  task automatic wait_busy(input logic lvl);
    for (int k = 0; k < 200 && busy !== lvl; k++) step(1);
    chk("R6 wait", {31'd0, busy}, {31'd0, lvl});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    // R11 reset state
    chk("R11 dout_en", {31'd0, dout_en}, 32'd0);
    chk("R11 dout", {24'd0, dout}, 32'd0);
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 page_err", {31'd0, page_err}, 32'd0);

    // table walk: one page load with varied gaps (R3, R4)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][32:16], VEC[i][15:8], 1'b1);
      if (i != NV-1) begin
        step((i % 3 == 0) ? 0 : ((i % 3 == 1) ? 7 : LW - 4));
        chk("R4 load open", {31'd0, busy}, 32'd0);
      end
    end
    // R5 exact start of programming
    step(LW - 3);
    chk("R5 before window", {31'd0, busy}, 32'd0);
    step(1);
    chk("R5 at window", {31'd0, busy}, 32'd1);
    // R7/R8 status: last data C3 -> bit7 0; toggle 0->1->0
    rd("R7 R8 status1", 17'h00500, 8'h40);
    rd("R7 R8 status2", 17'h00500, 8'h00);
    step(PC - 5);
    chk("R6 still busy", {31'd0, busy}, 32'd1);
    step(1);
    chk("R6 done", {31'd0, busy}, 32'd0);
    for (int i = 0; i < NV; i++) rd("R3 readback", VEC[i][32:16], VEC[i][7:0]);

    // page 2: read between loads, foreign page write, ignored writes
    wr(17'h00210, 8'h12, 1'b1);
    rd("R4 read during load", 17'h00500, 8'hA5);
    chk("R4 still loading", {31'd0, busy}, 32'd0);
    wr(17'h00500, 8'h77, 1'b1);
    chk("R9 page_err", {31'd0, page_err}, 32'd1);
    wr(17'h00203, 8'h5A, 1'b1);
    step(LW - 3);
    chk("R5 second page", {31'd0, busy}, 32'd0);
    step(1);
    chk("R5 second page", {31'd0, busy}, 32'd1);
    rd("R7 R8 status3", 17'h00203, 8'hC0);
    wr(17'h00203, 8'hFF, 1'b1);
    wr(17'h00300, 8'h01, 1'b1);
    wait_busy(1'b0);
    step(LW + 5);
    chk("R6 no load from ignored write", {31'd0, busy}, 32'd0);
    chk("R9 sticky", {31'd0, page_err}, 32'd1);
    rd("R3 page2 byte", 17'h00210, 8'h12);
    rd("R6 ignored write", 17'h00203, 8'h5A);
    rd("R9 discarded", 17'h00500, 8'hA5);

    // R1: write pattern with output enable low does nothing
    wr(17'h00500, 8'h00, 1'b0);
    step(LW + 2);
    chk("R1 no load", {31'd0, busy}, 32'd0);
    rd("R1 array intact", 17'h00500, 8'hA5);

    // R2: address from first clock, data from last active clock
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 17'h00540; din = 8'h11;
    step(1);
    addr = 17'h00500; din = 8'h66;
    step(1);
    we_n = 1'b1; ce_n = 1'b1; din = 8'hEE;
    step(1);
    wait_busy(1'b1);
    wait_busy(1'b0);
    rd("R2 latched address", 17'h00540, 8'h66);
    rd("R2 other address", 17'h00500, 8'hA5);

    // R10: enable rules and one-clock latency
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 17'h00540;
    step(1);
    chk("R10 oe high", {31'd0, dout_en}, 32'd0);
    ce_n = 1'b1; oe_n = 1'b0;
    step(1);
    chk("R10 ce high", {31'd0, dout_en}, 32'd0);
    chk("R10 dout zero", {24'd0, dout}, 32'd0);
    ce_n = 1'b0;
    #1;
    chk("R10 latency", {31'd0, dout_en}, 32'd0);
    step(1);
    chk("R10 read", {24'd0, dout}, 32'h66);
    ce_n = 1'b1; oe_n = 1'b1;
    step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule